// File: doc/BRIEF.md
# Converter Front-End SPI Configuration Sequencer

This block brings a data-converter front end out of power-up and into a working configuration without help from software. It first holds the converter's reset output high for a set number of clock cycles. It then waits a further settling time. After that it steps through a fixed script. Most script steps are 24-bit serial register writes, each an 8-bit address followed by 16 bits of data. The script also contains timed pauses, one after the PLL reset and one between the two halves of a register toggle, and it raises a trigger line for a few converter clocks at one point.

When the last word of the script has been shifted out, `init_done` rises and the block starts serving run-time writes. Each accepted request is acknowledged and becomes two serial words. The first word selects the register bank: `0x000000` for the ADC bank or `0x000010` for the TGC bank. The second word carries the requested address and data. Every wait length is a parameter counted in system clock cycles, so a simulation can shrink the waits without changing the order of the steps.

Top module: `fe_cfg_sequencer`

## Requirements
- R1: While `rst` is high and for exactly `RST_CYC` cycles after it falls, `fe_rst` is 1, `spi_sen` is 1 and `spi_sclk` is 0; `init_done`, `ack` and `fe_trig` are 0 during reset.
- R2: The first falling edge of `spi_sen` comes at least `HOLD_CYC` cycles after `fe_rst` falls.
- R3: Each word is framed by `spi_sen` low for exactly 24 rising edges of `spi_sclk`. The device samples `spi_sdata` on each rising edge, and the word is sent MSB first: the address in bits 23:16, the data in bits 15:0. `spi_sclk` is 0 whenever `spi_sen` is 1.
- R4: Between two words, `spi_sen` stays high for at least one SCLK period, which is `2*CLK_DIV` system cycles.
- R5: The initialization words appear in this order: 000000, 030010, D10007, D40001, 418000, 428000, 410000, 420000, 010000, 040010, 030010, 020100, 020080, 150009, 210009, 2D0009, 390009, C70000, 020380, 020000 (hex).
- R6: The gap between the end of word 4 (D40001) and the start of word 5 is at least `PLL_WAIT_CYC` cycles.
- R7: The gap between the end of word 6 (428000) and the start of word 7 is at least `LOCK_WAIT_CYC` cycles.
- R8: `fe_trig` is high exactly once, for `TRIG_CYC` consecutive cycles, after word 10 and before word 11, with `spi_sen` high for the whole pulse.
- R9: `init_done` stays 0 until all 20 script words have completed. It rises within `2*CLK_DIV+4` cycles after the last word ends and then stays 1 until reset.
- R10: A request made before `init_done` is 1 is ignored: it produces no `ack` and no word.
- R11: A request is accepted when `init_done` is 1 and no run-time write is in progress. `ack` then pulses for one cycle, and two words follow: the bank word (0x000000 when `req_bank`=0, 0x000010 when `req_bank`=1), then `{req_addr, req_data}`. `req` must be held until `ack` is seen.
- R12: A request raised while a run-time write is in progress is ignored: it produces no `ack` and no extra word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_sen | output | 1 | Serial enable, active low for one word |
| spi_sdata | output | 1 | Serial data, MSB first |
| fe_rst | output | 1 | Reset to the converter |
| fe_trig | output | 1 | Trigger pulse to the converter |
| init_done | output | 1 | Script complete, run-time writes open |
| req | input | 1 | Run-time write request |
| req_bank | input | 1 | Bank select: 0 ADC, 1 TGC |
| req_addr | input | 8 | Register address of the run-time write |
| req_data | input | 16 | Register data of the run-time write |
| ack | output | 1 | One-cycle acceptance pulse |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. They check SCLK framing: the clock idles low while the enable is high, each frame has 24 rising edges, and the gap between frames is at least one SCLK period. They also check that the bus stays quiet while the converter is in reset or the trigger is high, that `init_done` never drops, and that `ack` is a single-cycle pulse which only occurs once initialization is finished. Other behaviour can only be shown by the bench's scenarios, because it needs a decoded history of the pins. These are the exact word sequence, the measured pauses after the PLL reset and the register toggle, where the trigger falls in the word order, and the fact that early or overlapping requests leave the word stream unchanged.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;

    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int BITCNT_W = 5;
    localparam int PC_W     = 5;

    typedef enum logic [2:0] {
        OP_WRITE      = 3'd0,
        OP_WAIT_LONG  = 3'd1,
        OP_WAIT_SHORT = 3'd2,
        OP_TRIG       = 3'd3,
        OP_END        = 3'd4
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [WORD_W-1:0]  word;
    } step_t;

    typedef struct packed {
        logic               bank;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } rt_req_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_e;

    typedef enum logic [3:0] {
        SQ_RST     = 4'd0,
        SQ_HOLD    = 4'd1,
        SQ_FETCH   = 4'd2,
        SQ_SEND    = 4'd3,
        SQ_WAIT    = 4'd4,
        SQ_TRIG    = 4'd5,
        SQ_READY   = 4'd6,
        SQ_RT_BANK = 4'd7,
        SQ_RT_DATA = 4'd8
    } sq_state_e;

    function automatic int lmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] bank_word(input logic bank);
        return bank ? 24'h00_0010 : 24'h00_0000;
    endfunction

    function automatic step_t wr(input logic [WORD_W-1:0] w);
        step_t s;
        s.op   = OP_WRITE;
        s.word = w;
        return s;
    endfunction

    function automatic step_t ctl(input op_e o);
        step_t s;
        s.op   = o;
        s.word = '0;
        return s;
    endfunction

    // Boot script: writes interleaved with timed steps.
    function automatic step_t script_step(input logic [PC_W-1:0] idx);
        case (idx)
            5'd0:    return wr(24'h00_0000);
            5'd1:    return wr(24'h03_0010);
            5'd2:    return wr(24'hD1_0007);
            5'd3:    return wr(24'hD4_0001);
            5'd4:    return ctl(OP_WAIT_LONG);
            5'd5:    return wr(24'h41_8000);
            5'd6:    return wr(24'h42_8000);
            5'd7:    return ctl(OP_WAIT_SHORT);
            5'd8:    return wr(24'h41_0000);
            5'd9:    return wr(24'h42_0000);
            5'd10:   return wr(24'h01_0000);
            5'd11:   return wr(24'h04_0010);
            5'd12:   return ctl(OP_TRIG);
            5'd13:   return wr(24'h03_0010);
            5'd14:   return wr(24'h02_0100);
            5'd15:   return wr(24'h02_0080);
            5'd16:   return wr(24'h15_0009);
            5'd17:   return wr(24'h21_0009);
            5'd18:   return wr(24'h2D_0009);
            5'd19:   return wr(24'h39_0009);
            5'd20:   return wr(24'hC7_0000);
            5'd21:   return wr(24'h02_0380);
            5'd22:   return wr(24'h02_0000);
            default: return ctl(OP_END);
        endcase
    endfunction

endpackage

// File: rtl/fe_cfg_script_rom.sv
module fe_cfg_script_rom
    import fe_cfg_pkg::*;
(
    input  logic [PC_W-1:0] idx,
    output step_t           step
);
    always_comb begin
        step = script_step(idx);
    end
endmodule

// File: rtl/fe_cfg_timer.sv
module fe_cfg_timer #(
    parameter int CNT_W = 16,
    parameter int INIT  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(INIT);
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fe_cfg_spi_tx.sv
module fe_cfg_spi_tx
    import fe_cfg_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              done,
    output logic              sclk,
    output logic              sen,
    output logic              sdata
);
    localparam int GAP_LEN = 2 * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_LEN + 1);

    tx_state_e           st;
    logic [GAP_W-1:0]    cnt;
    logic                sclk_q;
    logic [WORD_W-1:0]   sh;
    logic [BITCNT_W-1:0] bits_left;
    logic                half_end;

    assign half_end = (cnt == GAP_W'(CLK_DIV - 1));
    assign done     = (st == TX_GAP) && (cnt == GAP_W'(GAP_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= TX_IDLE;
            cnt       <= '0;
            sclk_q    <= 1'b0;
            sh        <= '0;
            bits_left <= '0;
        end else if (start && (st == TX_IDLE || done)) begin
            st        <= TX_SHIFT;
            cnt       <= '0;
            sclk_q    <= 1'b0;
            sh        <= word;
            bits_left <= BITCNT_W'(WORD_W - 1);
        end else begin
            case (st)
                TX_SHIFT: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bits_left == '0) begin
                                st <= TX_GAP;
                            end else begin
                                bits_left <= bits_left - 1'b1;
                                sh        <= {sh[WORD_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (done) begin
                        st  <= TX_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign sclk  = sclk_q;
    assign sen   = (st != TX_SHIFT);
    assign sdata = sh[WORD_W-1];
endmodule

// File: rtl/fe_cfg_sequencer.sv
module fe_cfg_sequencer
    import fe_cfg_pkg::*;
#(
    parameter int CLK_DIV       = 2,
    parameter int RST_CYC       = 10,
    parameter int HOLD_CYC      = 10,
    parameter int PLL_WAIT_CYC  = 10000,
    parameter int LOCK_WAIT_CYC = 1000,
    parameter int TRIG_CYC      = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic              spi_sclk,
    output logic              spi_sen,
    output logic              spi_sdata,
    output logic              fe_rst,
    output logic              fe_trig,
    output logic              init_done,
    input  logic              req,
    input  logic              req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack
);
    localparam int MAX_LEN = lmax(lmax(lmax(RST_CYC, HOLD_CYC), lmax(PLL_WAIT_CYC, LOCK_WAIT_CYC)), TRIG_CYC);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    sq_state_e         st, st_n;
    logic [PC_W-1:0]   pc, pc_n;
    rt_req_t           rt_q, rt_n;
    logic              done_q, done_n;
    logic              ack_q, ack_n;

    step_t             step;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_zero;
    logic              tx_start;
    logic [WORD_W-1:0] tx_word;
    logic              tx_done;

    fe_cfg_script_rom u_rom (
        .idx  (pc),
        .step (step)
    );

    fe_cfg_timer #(
        .CNT_W (CNT_W),
        .INIT  (RST_CYC - 1)
    ) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .zero (tmr_zero)
    );

    fe_cfg_spi_tx #(
        .CLK_DIV (CLK_DIV)
    ) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (tx_start),
        .word  (tx_word),
        .done  (tx_done),
        .sclk  (spi_sclk),
        .sen   (spi_sen),
        .sdata (spi_sdata)
    );

    always_comb begin
        st_n     = st;
        pc_n     = pc;
        rt_n     = rt_q;
        done_n   = done_q;
        ack_n    = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        tx_start = 1'b0;
        tx_word  = '0;
        case (st)
            SQ_RST: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(HOLD_CYC - 1);
                    st_n     = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                if (tmr_zero) begin
                    st_n = SQ_FETCH;
                end
            end
            SQ_FETCH: begin
                pc_n = pc + 1'b1;
                case (step.op)
                    OP_WRITE: begin
                        tx_start = 1'b1;
                        tx_word  = step.word;
                        st_n     = SQ_SEND;
                    end
                    OP_WAIT_LONG: begin
                        tmr_load = 1'b1;
                        tmr_len  = CNT_W'(PLL_WAIT_CYC - 1);
                        st_n     = SQ_WAIT;
                    end
                    OP_WAIT_SHORT: begin
                        tmr_load = 1'b1;
                        tmr_len  = CNT_W'(LOCK_WAIT_CYC - 1);
                        st_n     = SQ_WAIT;
                    end
                    OP_TRIG: begin
                        tmr_load = 1'b1;
                        tmr_len  = CNT_W'(TRIG_CYC - 1);
                        st_n     = SQ_TRIG;
                    end
                    default: begin
                        pc_n   = pc;
                        done_n = 1'b1;
                        st_n   = SQ_READY;
                    end
                endcase
            end
            SQ_SEND: begin
                if (tx_done) begin
                    st_n = SQ_FETCH;
                end
            end
            SQ_WAIT, SQ_TRIG: begin
                if (tmr_zero) begin
                    st_n = SQ_FETCH;
                end
            end
            SQ_READY: begin
                if (req) begin
                    rt_n.bank = req_bank;
                    rt_n.addr = req_addr;
                    rt_n.data = req_data;
                    ack_n     = 1'b1;
                    tx_start  = 1'b1;
                    tx_word   = bank_word(req_bank);
                    st_n      = SQ_RT_BANK;
                end
            end
            SQ_RT_BANK: begin
                if (tx_done) begin
                    tx_start = 1'b1;
                    tx_word  = {rt_q.addr, rt_q.data};
                    st_n     = SQ_RT_DATA;
                end
            end
            SQ_RT_DATA: begin
                if (tx_done) begin
                    st_n = SQ_READY;
                end
            end
            default: begin
                st_n = SQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_RST;
            pc     <= '0;
            rt_q   <= '0;
            done_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            st     <= st_n;
            pc     <= pc_n;
            rt_q   <= rt_n;
            done_q <= done_n;
            ack_q  <= ack_n;
        end
    end

    assign fe_rst    = (st == SQ_RST);
    assign fe_trig   = (st == SQ_TRIG);
    assign init_done = done_q;
    assign ack       = ack_q;
endmodule

// File: rtl/fe_cfg_sequencer_chk.sv
module fe_cfg_sequencer_chk #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic sen,
    input logic sclk,
    input logic fe_rst,
    input logic fe_trig,
    input logic init_done,
    input logic ack
);
    localparam int GAP_MIN = 2 * CLK_DIV;

    logic        sen_q, sclk_q;
    logic [5:0]  rise_cnt;
    logic [15:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sen_q    <= 1'b1;
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
            high_cnt <= '0;
        end else begin
            sen_q  <= sen;
            sclk_q <= sclk;
            if (!sen && sen_q) begin
                rise_cnt <= '0;
            end else if (!sen && sclk && !sclk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            if (sen) begin
                if (high_cnt < 16'(GAP_MIN)) high_cnt <= high_cnt + 1'b1;
            end else begin
                high_cnt <= '0;
            end
        end
    end

    // R3: clock idles low outside a frame
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        sen |-> !sclk);

    // R3: every frame carries 24 rising edges
    a_r3_frame_bits: assert property (@(posedge clk) disable iff (rst)
        (sen && !sen_q) |-> (rise_cnt == 6'd24));

    // R4: minimum idle time between frames
    a_r4_frame_gap: assert property (@(posedge clk) disable iff (rst)
        (!sen && sen_q) |-> (high_cnt >= 16'(GAP_MIN)));

    // R1: no serial traffic while the converter is held in reset
    a_r1_rst_quiet: assert property (@(posedge clk) disable iff (rst)
        fe_rst |-> sen);

    // R8: trigger only during the script and with the bus idle
    a_r8_trig_quiet: assert property (@(posedge clk) disable iff (rst)
        fe_trig |-> (sen && !init_done));

    // R9: completion flag is sticky
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R10: acknowledgement only after initialization
    a_r10_ack_ready: assert property (@(posedge clk) disable iff (rst)
        ack |-> init_done);

    // R11: acknowledgement lasts a single cycle
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
endmodule

bind fe_cfg_sequencer fe_cfg_sequencer_chk #(
    .CLK_DIV (CLK_DIV)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sen       (spi_sen),
    .sclk      (spi_sclk),
    .fe_rst    (fe_rst),
    .fe_trig   (fe_trig),
    .init_done (init_done),
    .ack       (ack)
);

// File: tb/sim_fe_cfg_sequencer.sv
module sim_fe_cfg_sequencer;

    localparam int CLK_DIV   = 2;
    localparam int RST_CYC   = 10;
    localparam int HOLD_CYC  = 10;
    localparam int PLL_WAIT  = 400;
    localparam int LOCK_WAIT = 120;
    localparam int TRIG_CYC  = 3;
    localparam int N_INIT    = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk, spi_sen, spi_sdata;
    logic        fe_rst, fe_trig, init_done, ack;
    logic        req = 1'b0;
    logic        req_bank = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_data = '0;

    always #5 clk = ~clk;

    fe_cfg_sequencer #(
        .CLK_DIV       (CLK_DIV),
        .RST_CYC       (RST_CYC),
        .HOLD_CYC      (HOLD_CYC),
        .PLL_WAIT_CYC  (PLL_WAIT),
        .LOCK_WAIT_CYC (LOCK_WAIT),
        .TRIG_CYC      (TRIG_CYC)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_sen   (spi_sen),
        .spi_sdata (spi_sdata),
        .fe_rst    (fe_rst),
        .fe_trig   (fe_trig),
        .init_done (init_done),
        .req       (req),
        .req_bank  (req_bank),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .ack       (ack)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: expected word stream
    logic [23:0] exp_q[$];

    initial begin
        exp_q = '{24'h000000, 24'h030010, 24'hD10007, 24'hD40001, 24'h418000,
                  24'h428000, 24'h410000, 24'h420000, 24'h010000, 24'h040010,
                  24'h030010, 24'h020100, 24'h020080, 24'h150009, 24'h210009,
                  24'h2D0009, 24'h390009, 24'hC70000, 24'h020380, 24'h020000};
    end

    // Pin decoder and per-cycle comparison
    int          cyc = 0;
    int          words_done = 0;
    int          last_end = 0;
    int          rst_fall = 0;
    int          nbits = 0;
    int          trig_run = 0;
    int          trig_at = -1;
    int          trig_pulses = 0;
    int          ack_cnt = 0;
    logic [23:0] shreg = '0;
    logic        p_sen = 1'b1;
    logic        p_sclk = 1'b0;
    logic        p_trig = 1'b0;
    logic        p_fe_rst = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(!(spi_sen && spi_sclk), "R3 sclk idle low", spi_sclk, 0);
            if (!fe_rst && p_fe_rst) rst_fall = cyc;
            if (!spi_sen && p_sen) begin
                nbits = 0;
                if (words_done == 0)
                    chk(cyc - rst_fall >= HOLD_CYC, "R2 hold after reset", cyc - rst_fall, HOLD_CYC);
                else
                    chk(cyc - last_end >= 2 * CLK_DIV, "R4 inter-word gap", cyc - last_end, 2 * CLK_DIV);
                if (words_done == 4)
                    chk(cyc - last_end >= PLL_WAIT, "R6 PLL wait", cyc - last_end, PLL_WAIT);
                if (words_done == 6)
                    chk(cyc - last_end >= LOCK_WAIT, "R7 toggle wait", cyc - last_end, LOCK_WAIT);
            end
            if (!spi_sen && spi_sclk && !p_sclk) begin
                shreg = {shreg[22:0], spi_sdata};
                nbits++;
            end
            if (spi_sen && !p_sen) begin
                chk(nbits == 24, "R3 bits per word", nbits, 24);
                last_end = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected word", shreg, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    if (words_done < N_INIT) chk(shreg == e, "R5 script word", shreg, e);
                    else                     chk(shreg == e, "R11 runtime word", shreg, e);
                end
                words_done++;
            end
            if (fe_trig) begin
                if (!p_trig) trig_at = words_done;
                trig_run++;
                chk(spi_sen, "R8 bus idle during trigger", spi_sen, 1);
            end else if (p_trig) begin
                trig_pulses++;
                chk(trig_run == TRIG_CYC, "R8 trigger length", trig_run, TRIG_CYC);
                chk(trig_at == 10, "R8 trigger position", trig_at, 10);
                trig_run = 0;
            end
            chk(!(init_done && words_done < N_INIT), "R9 done too early", words_done, N_INIT);
            if (ack) begin
                ack_cnt++;
                chk(init_done, "R10 ack before done", init_done, 1);
            end
        end
        p_sen    = spi_sen;
        p_sclk   = spi_sclk;
        p_trig   = fe_trig;
        p_fe_rst = fe_rst;
    end

    task automatic wait_words(input int n);
        while (words_done < n) @(negedge clk);
    endtask

    task automatic rt_write(input logic bank, input logic [7:0] a, input logic [15:0] d);
        int n;
        exp_q.push_back(bank ? 24'h000010 : 24'h000000);
        exp_q.push_back({a, d});
        req_bank = bank;
        req_addr = a;
        req_data = d;
        req      = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 200);
        chk(ack, "R11 ack seen", ack, 1);
        req = 1'b0;
        @(negedge clk);
        chk(!ack, "R11 ack single cycle", ack, 0);
    endtask

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        chk(fe_rst && spi_sen && !spi_sclk && !init_done && !ack && !fe_trig,
            "R1 reset state", {fe_rst, spi_sen, spi_sclk, init_done, ack, fe_trig}, 6'b110000);
        rst = 1'b0;
        hi = 0;
        #1;
        while (fe_rst) begin
            hi++;
            @(negedge clk);
            #1;
        end
        chk(hi == RST_CYC, "R1 reset pulse length", hi, RST_CYC);

        // R10: request during the PLL wait must be ignored
        wait_words(4);
        @(negedge clk);
        req_bank = 1'b1;
        req_addr = 8'hAA;
        req_data = 16'h5555;
        req      = 1'b1;
        repeat (30) @(negedge clk);
        req = 1'b0;
        chk(ack_cnt == 0, "R10 early request ignored", ack_cnt, 0);

        while (!init_done) @(negedge clk);
        chk(words_done == N_INIT, "R9 words before done", words_done, N_INIT);
        chk(exp_q.size() == 0, "R5 script complete", exp_q.size(), 0);
        chk(cyc - last_end <= 2 * CLK_DIV + 4, "R9 done latency", cyc - last_end, 2 * CLK_DIV + 4);

        // R11: TGC bank write
        rt_write(1'b1, 8'h15, 16'h1234);

        // R12: request while the transaction is still shifting
        repeat (10) @(negedge clk);
        req_bank = 1'b0;
        req_addr = 8'h77;
        req_data = 16'hBEEF;
        req      = 1'b1;
        repeat (3) @(negedge clk);
        req = 1'b0;
        wait_words(N_INIT + 2);
        repeat (60) @(negedge clk);
        chk(words_done == N_INIT + 2, "R12 no extra words", words_done, N_INIT + 2);
        chk(ack_cnt == 1, "R12 no extra ack", ack_cnt, 1);

        // R11: ADC bank write
        rt_write(1'b0, 8'hC7, 16'h0001);
        wait_words(N_INIT + 4);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R11 runtime words drained", exp_q.size(), 0);
        chk(init_done, "R9 done sticky", init_done, 1);
        chk(trig_pulses == 1, "R8 single trigger", trig_pulses, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual %0d expected %0d", words_done, N_INIT + 4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule